// File: doc/BRIEF.md
# SAR ADC to Left-Justified Audio Bridge

This block sits between a pair of daisy-chained 20-bit successive-approximation converters and a left-justified stereo audio serial port. Running from the master audio clock, it divides that clock into a bit clock and a frame clock. It also derives a single conversion-start pulse from the falling edge of the frame clock. Both converters share that pulse, so they sample at the same instant. After a fixed conversion wait, the block clocks the converter chain with a burst of serial clocks and collects both results in one pass.

The collected results go out in the following frame. Each one is placed in a 24-bit slot, MSB first, starting on the first bit clock of the slot. The left sample occupies the low half of the frame and the right sample the high half. The four bit times after each 20-bit sample are driven as zeros.

Frame length, slot width, sample width, bit-clock divider, conversion pulse width and conversion wait are all parameters. With the defaults, one frame is 48 bit clocks of 2 master cycles each, so a frame lasts 96 master cycles.

Top module: `sar_lj_bridge`

## Requirements
- R1: A frame is 2*SLOT_BITS bit clocks (48 by default). The frame clock `lrck` is low for the first SLOT_BITS bits, which form the left slot, and high for the next SLOT_BITS bits, which form the right slot.
- R2: `bclk` has a period of BCLK_DIV master cycles. It is low during the first half of each bit and high during the second half. `sdata` and `lrck` change only in a master cycle in which `bclk` falls.
- R3: `adc_cnv` rises exactly once per frame, in the same master cycle that `lrck` falls. Successive rising edges are 2*SLOT_BITS*BCLK_DIV master cycles apart.
- R4: `adc_cnv` stays high for exactly CNV_HIGH master cycles (default 4).
- R5: `adc_sck` is never high while `adc_cnv` is high. The first rising edge of `adc_sck` comes no earlier than CONV_WAIT master cycles (default 12) after the rising edge of `adc_cnv`.
- R6: Each frame carries exactly 2*ADC_BITS pulses on `adc_sck`. The block samples `adc_sdo` on each rising edge of `adc_sck`. The chain is expected to shift on each falling edge.
- R7: The first ADC_BITS bits read from the chain form the left sample and the next ADC_BITS bits form the right sample. Each sample is sent MSB first, with its MSB on the first bit of its slot (no one-bit delay).
- R8: The SLOT_BITS-ADC_BITS bit times that follow each sample in its slot are zero.
- R9: A pair converted after the conversion pulse of frame n is sent in frame n+1.
- R10: In the first frame after reset, no conversion has completed yet, so both slots are all zeros.
- R11: While reset is held, `bclk` and `lrck` are high and `adc_cnv`, `adc_sck` and `sdata` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mclk | input | 1 | Master audio clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adc_sdo | input | 1 | Serial data from the end of the converter chain |
| adc_cnv | output | 1 | Shared conversion-start pulse |
| adc_sck | output | 1 | Serial clock to the converter chain |
| bclk | output | 1 | Audio bit clock |
| lrck | output | 1 | Audio frame clock, low for left |
| sdata | output | 1 | Left-justified audio serial data |

## Verification
All outputs are registered from the frame counter, so every output reflects the counter one master cycle later. A conversion pulse issued in frame n therefore shows up as audio in frame n+1, 96 master cycles later by default. The bench samples `sdata` and `lrck` one nanosecond after each rising edge of `bclk`, which falls in the middle of a bit. It samples the conversion and serial-clock pins one nanosecond after each master edge and measures pulse widths, spacings and wait times in master cycles. Each frame's 48 received bits are compared against the codes that the behavioural chain model loaded at the previous conversion pulse.

// File: rtl/sar_lj_bridge.sv
module sar_lj_bridge #(
  parameter int ADC_BITS  = 20,
  parameter int SLOT_BITS = 24,
  parameter int BCLK_DIV  = 2,
  parameter int CNV_HIGH  = 4,
  parameter int CONV_WAIT = 12
) (
  input  logic mclk,
  input  logic rst_n,
  input  logic adc_sdo,
  output logic adc_cnv,
  output logic adc_sck,
  output logic bclk,
  output logic lrck,
  output logic sdata
);
  localparam int CHAIN_BITS = 2 * ADC_BITS;
  localparam int FRAME_BITS = 2 * SLOT_BITS;
  localparam int FRAME_M    = FRAME_BITS * BCLK_DIV;
  localparam int PAD        = SLOT_BITS - ADC_BITS;
  localparam int MW         = $clog2(FRAME_M);
  localparam int PW         = $clog2(BCLK_DIV);
  localparam int BW         = $clog2(FRAME_BITS);

  logic [MW-1:0] mc;
  logic [PW-1:0] ph;
  logic [BW-1:0] bidx;
  logic [MW-1:0] step;
  logic [BW-1:0] sel;
  logic [CHAIN_BITS-1:0] cap;
  logic [FRAME_BITS-1:0] out_word;
  logic rd_act, sck_n, ph_last, frame_last;

  assign ph_last    = ph == PW'(BCLK_DIV - 1);
  assign frame_last = mc == MW'(FRAME_M - 1);
  assign step       = mc - MW'(CONV_WAIT);
  assign rd_act     = (mc >= MW'(CONV_WAIT)) && (mc < MW'(CONV_WAIT + 2 * CHAIN_BITS));
  assign sck_n      = rd_act && !step[0];
  assign sel        = BW'(FRAME_BITS - 1) - bidx;

  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n) begin
      mc   <= '0;
      ph   <= '0;
      bidx <= '0;
    end else begin
      mc <= frame_last ? '0 : mc + 1'b1;
      ph <= ph_last ? '0 : ph + 1'b1;
      if (ph_last) bidx <= (bidx == BW'(FRAME_BITS - 1)) ? '0 : bidx + 1'b1;
    end
  end

  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n) begin
      cap      <= '0;
      out_word <= '0;
    end else begin
      if (sck_n) cap <= {cap[CHAIN_BITS-2:0], adc_sdo};
      if (frame_last)
        out_word <= {cap[CHAIN_BITS-1 -: ADC_BITS], {PAD{1'b0}},
                     cap[ADC_BITS-1:0], {PAD{1'b0}}};
    end
  end

  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n) begin
      adc_cnv <= 1'b0;
      adc_sck <= 1'b0;
      bclk    <= 1'b1;
      lrck    <= 1'b1;
      sdata   <= 1'b0;
    end else begin
      adc_cnv <= mc < MW'(CNV_HIGH);
      adc_sck <= sck_n;
      bclk    <= ph >= PW'(BCLK_DIV / 2);
      lrck    <= bidx >= BW'(SLOT_BITS);
      sdata   <= out_word[sel];
    end
  end
endmodule

module sar_lj_bridge_chk #(
  parameter int CNV_HIGH = 4
) (
  input logic mclk,
  input logic rst_n,
  input logic adc_cnv,
  input logic adc_sck,
  input logic bclk,
  input logic lrck,
  input logic sdata
);
  int hcnt;

  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n) hcnt <= 0;
    else        hcnt <= adc_cnv ? hcnt + 1 : 0;
  end

  // R2
  lrck_on_bclk_fall_chk: assert property (@(posedge mclk) disable iff (!rst_n)
    !$stable(lrck) |-> $fell(bclk));
  // R2
  sdata_on_bclk_fall_chk: assert property (@(posedge mclk) disable iff (!rst_n)
    !$stable(sdata) |-> $fell(bclk));
  // R3
  cnv_on_lrck_fall_chk: assert property (@(posedge mclk) disable iff (!rst_n)
    $rose(adc_cnv) |-> $fell(lrck));
  // R4
  cnv_width_chk: assert property (@(posedge mclk) disable iff (!rst_n)
    $fell(adc_cnv) |-> (hcnt == CNV_HIGH));
  // R5
  sck_quiet_chk: assert property (@(posedge mclk) disable iff (!rst_n)
    !(adc_cnv && adc_sck));
endmodule

bind sar_lj_bridge sar_lj_bridge_chk #(.CNV_HIGH(CNV_HIGH)) u_chk (
  .mclk(mclk), .rst_n(rst_n), .adc_cnv(adc_cnv), .adc_sck(adc_sck),
  .bclk(bclk), .lrck(lrck), .sdata(sdata)
);

// File: tb/sar_lj_bridge_test.sv
`timescale 1ns/1ps
module sar_lj_bridge_test;
  localparam int ADC_BITS = 20, SLOT_BITS = 24, BCLK_DIV = 2, CNV_HIGH = 4, CONV_WAIT = 12;
  localparam int FRAME_BITS = 2 * SLOT_BITS;
  localparam int FRAME_M = FRAME_BITS * BCLK_DIV;
  localparam int NFRAMES = 20;

  logic mclk = 0, rst_n = 0, adc_sdo;
  logic adc_cnv, adc_sck, bclk, lrck, sdata;
  int nchk = 0, nfail = 0;

  sar_lj_bridge #(.ADC_BITS(ADC_BITS), .SLOT_BITS(SLOT_BITS), .BCLK_DIV(BCLK_DIV),
                  .CNV_HIGH(CNV_HIGH), .CONV_WAIT(CONV_WAIT)) uut (
    .mclk(mclk), .rst_n(rst_n), .adc_sdo(adc_sdo), .adc_cnv(adc_cnv),
    .adc_sck(adc_sck), .bclk(bclk), .lrck(lrck), .sdata(sdata));

  always #2.5 mclk = ~mclk;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [19:0] code(input int k, input int ch);
    case (k)
      0: return ch == 0 ? 20'hFFFFF : 20'h00000;
      1: return ch == 0 ? 20'h00000 : 20'hFFFFF;
      2: return ch == 0 ? 20'h80000 : 20'h7FFFF;
      3: return ch == 0 ? 20'hAAAAA : 20'h55555;
      4: return ch == 0 ? 20'h00001 : 20'h80001;
      default: return 20'((k * 32'h1F3B7) ^ (ch * 32'h9E37B) ^ (k << 13));
    endcase
  endfunction

  // behavioural two-converter chain: loads on conversion start, shifts on sck fall
  logic [2*ADC_BITS-1:0] chain = '0;
  int kconv = 0;
  assign adc_sdo = chain[2*ADC_BITS-1];
  always @(posedge adc_cnv or negedge adc_sck) begin
    if (adc_cnv) begin
      chain = {code(kconv, 0), code(kconv, 1)};
      kconv++;
    end else chain = chain << 1;
  end

  // conversion/serial clock monitor
  int since = 0, width = 0, nsck = 0, ncnv = 0;
  logic pcnv = 0, psck = 0, plr = 1;
  bit first_sck = 1;
  always @(posedge mclk) begin
    #1;
    if (rst_n) begin
      since++;
      if (adc_cnv && !pcnv) begin
        check(!lrck && plr, "R3 cnv rise with lrck fall", {plr, lrck}, 2'b10);
        if (ncnv > 0) begin
          check(since == FRAME_M, "R3 cnv period", since, FRAME_M);
          check(nsck == 2 * ADC_BITS, "R6 sck pulses per frame", nsck, 2 * ADC_BITS);
        end
        ncnv++; since = 0; width = 0; nsck = 0; first_sck = 1;
      end
      if (adc_cnv) width++;
      if (!adc_cnv && pcnv) check(width == CNV_HIGH, "R4 cnv width", width, CNV_HIGH);
      if (adc_sck && adc_cnv) check(0, "R5 sck during cnv", 1, 0);
      if (adc_sck && !psck) begin
        nsck++;
        if (first_sck) begin
          check(since >= CONV_WAIT, "R5 conversion wait", since, CONV_WAIT);
          first_sck = 0;
        end
      end
      pcnv = adc_cnv; psck = adc_sck; plr = lrck;
    end
  end

  // audio receiver
  int bc = 0, fr = 0, lrbad = 0;
  logic [FRAME_BITS-1:0] rx;
  always @(posedge bclk) begin
    #1;
    if (rst_n) begin
      rx[FRAME_BITS-1-bc] = sdata;
      if (lrck != (bc >= SLOT_BITS)) lrbad++;
      bc++;
      if (bc == FRAME_BITS) begin
        logic [19:0] el, er;
        el = (fr == 0) ? 20'h0 : code(fr - 1, 0);
        er = (fr == 0) ? 20'h0 : code(fr - 1, 1);
        check(lrbad == 0, "R1 lrck slot level", lrbad, 0);
        if (fr == 0)
          check(rx == '0, "R10 first frame silent", rx, 0);
        check(rx[47:28] == el, "R7 R9 left sample", rx[47:28], el);
        check(rx[23:4] == er, "R7 R9 right sample", rx[23:4], er);
        check(rx[27:24] == 4'h0 && rx[3:0] == 4'h0, "R8 pad zeros",
              {rx[27:24], rx[3:0]}, 0);
        bc = 0; lrbad = 0; fr++;
      end
    end
  end

  // bit clock period and edge alignment
  int bper = 0;
  logic pb = 1;
  always @(posedge mclk) begin
    #1;
    if (rst_n) begin
      bper++;
      if (bclk && !pb) begin
        if (fr > 0 || bc > 1) check(bper == BCLK_DIV, "R2 bclk period", bper, BCLK_DIV);
        bper = 0;
      end
      pb = bclk;
    end
  end

  initial begin
    repeat (3) @(posedge mclk);
    #1;
    check({bclk, lrck, adc_cnv, adc_sck, sdata} == 5'b11000, "R11 reset state",
          {bclk, lrck, adc_cnv, adc_sck, sdata}, 5'b11000);
    @(negedge mclk);
    rst_n = 1;
    fork
      begin
        wait (fr == NFRAMES);
      end
      begin
        repeat (100000) @(posedge mclk);
        check(0, "watchdog", fr, NFRAMES);
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule